// File: doc/BRIEF.md
# Dual-Core Interrupt Steering Logic

This block sits between two independent controller cores and the interrupt pins of the chip. Each core raises a level interrupt request. The block sends that request either to the host's active-low interrupt lines A and B, or to a pair of active-low secondary lines C and D. Lines C and D serve an optional coprocessor card placed in an add-in slot. A presence pin on that slot drives an active-low direction input. While the pin is asserted, cores in the default mode are steered to the card and are fully hidden from the host.

Each core owns a 2-bit routing-mode field, written through a small per-core write strobe. The field selects one of four routings:
- Mode 0 follows the direction pin.
- Mode 1 always goes to the host.
- Mode 2 always goes to the card.
- Mode 3 masks the core.

The direction input is synchronised by two flops before it is used. Every output is registered.

Top module: `irq_steer`

## Requirements
- R1: During and after reset, all four interrupt outputs are high (deasserted) and both mode fields are 0.
- R2: In mode 0 with `card_dir_ni` high, a high request from core i drives `host_irq_no[i]` low one clock edge after it is seen, and `card_irq_no[i]` stays high.
- R3: In mode 0 with `card_dir_ni` low, a high request from core i drives `card_irq_no[i]` low, and `host_irq_no[i]` stays high.
- R4: A core's request never appears on both of its lines at once, and never on a line that belongs to the other core. Core 0 owns A (`host_irq_no[0]`) and C (`card_irq_no[0]`); core 1 owns B (`host_irq_no[1]`) and D (`card_irq_no[1]`).
- R5: In mode 1 (field value 2'b01), a core goes to its host line whatever the level of `card_dir_ni`.
- R6: In mode 2 (field value 2'b10), a core goes to its card line whatever the level of `card_dir_ni`.
- R7: In mode 3 (field value 2'b11), both lines of the core stay high whatever its request.
- R8: `mode_we_i[i]` loads `mode_wdata_i[2*i+1:2*i]` into the field of core i only. The field of the other core keeps its value.
- R9: A change on `card_dir_ni` reaches the outputs at the third rising clock edge after the change, and has no effect at the first two.
- R10: Outputs are level-following. An output deasserts one edge after its request drops. It asserts again one edge after the request is high again, as happens when further interrupts are still stacked in the core.
- R11: A mode write reaches the outputs at the second rising edge after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 2 | Level interrupt request from each core |
| mode_we_i | input | 2 | Per-core write strobe for the mode field |
| mode_wdata_i | input | 4 | Mode data; bits [2i+1:2i] belong to core i |
| card_dir_ni | input | 1 | Add-in card direction pin, active low, asynchronous |
| host_irq_no | output | 2 | Host interrupt lines A (bit 0) and B (bit 1), active low |
| card_irq_no | output | 2 | Add-in interrupt lines C (bit 0) and D (bit 1), active low |

## Verification
The hardest case to reach is a direction-pin edge while a request is already pending. Two flops of synchroniser and one output register lie between the pin and the outputs, so the old path must hold for exactly two edges before the new path takes over. The stimulus holds a request high, toggles `card_dir_ni` at a falling edge, and samples after each of the next three rising edges. A second tricky case is the stacked re-assertion. The request is dropped for a single cycle and then raised again, and the bench checks both the one-cycle release and the new assertion.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  typedef enum logic [1:0] {
    MODE_FOLLOW = 2'b00,
    MODE_HOST   = 2'b01,
    MODE_CARD   = 2'b10,
    MODE_MASK   = 2'b11
  } route_mode_e;
endpackage

// File: rtl/irq_dir_sync.sv
module irq_dir_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic sync_no
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '1;
    else         stage_q <= {stage_q[STAGES-2:0], async_ni};
  end

  assign sync_no = stage_q[STAGES-1];
endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg
  import irq_steer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  wdata_i,
  output route_mode_e mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_o <= MODE_FOLLOW;
    else if (we_i) mode_o <= route_mode_e'(wdata_i);
  end

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mode_o));
  a_r8_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mode_o == route_mode_e'($past(wdata_i))));
endmodule

// File: rtl/irq_core_route.sv
module irq_core_route
  import irq_steer_pkg::*;
(
  input  route_mode_e mode_i,
  input  logic        req_i,
  input  logic        card_sel_i,
  output logic        host_req_o,
  output logic        card_req_o
);
  always_comb begin
    host_req_o = 1'b0;
    card_req_o = 1'b0;
    unique case (mode_i)
      MODE_FOLLOW: begin
        host_req_o = req_i & ~card_sel_i;
        card_req_o = req_i &  card_sel_i;
      end
      MODE_HOST: host_req_o = req_i;
      MODE_CARD: card_req_o = req_i;
      MODE_MASK: ;
      default:   ;
    endcase
  end
endmodule

// File: rtl/irq_steer.sv
module irq_steer
  import irq_steer_pkg::*;
#(
  parameter int unsigned NUM_CORES   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned MW         = 2 * NUM_CORES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CORES-1:0] irq_req_i,
  input  logic [NUM_CORES-1:0] mode_we_i,
  input  logic [MW-1:0]        mode_wdata_i,
  input  logic                 card_dir_ni,
  output logic [NUM_CORES-1:0] host_irq_no,
  output logic [NUM_CORES-1:0] card_irq_no
);
  logic                 dir_sync_n;
  logic                 card_sel;
  route_mode_e          mode_q [NUM_CORES];
  logic [NUM_CORES-1:0] host_req, card_req;

  irq_dir_sync #(.STAGES(SYNC_STAGES)) u_dir_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_ni (card_dir_ni),
    .sync_no  (dir_sync_n)
  );

  assign card_sel = ~dir_sync_n;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    irq_mode_reg u_mode (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (mode_we_i[c]),
      .wdata_i (mode_wdata_i[2*c +: 2]),
      .mode_o  (mode_q[c])
    );

    irq_core_route u_route (
      .mode_i     (mode_q[c]),
      .req_i      (irq_req_i[c]),
      .card_sel_i (card_sel),
      .host_req_o (host_req[c]),
      .card_req_o (card_req[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        host_irq_no[c] <= 1'b1;
        card_irq_no[c] <= 1'b1;
      end else begin
        host_irq_no[c] <= ~host_req[c];
        card_irq_no[c] <= ~card_req[c];
      end
    end

    // exclusive path per core
    a_r4_one_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
      host_irq_no[c] | card_irq_no[c]);
    // diverted core stays hidden from the host
    a_r3_host_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (card_sel && mode_q[c] == MODE_FOLLOW) |=> host_irq_no[c]);
    a_r7_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q[c] == MODE_MASK) |=> (host_irq_no[c] && card_irq_no[c]));
    a_r10_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_req_i[c] |=> (host_irq_no[c] && card_irq_no[c]));
    a_r5_forced_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q[c] == MODE_HOST && irq_req_i[c]) |=> !host_irq_no[c]);
  end
endmodule

// File: tb/irq_steer_tb.sv
module irq_steer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req = '0;
  logic [1:0] we = '0;
  logic [3:0] wdata = '0;
  logic       dir_n = 1'b1;
  logic [1:0] host_n, card_n;

  int checks = 0;
  int errors = 0;
  logic [1:0] m [2];

  always #4 clk = ~clk;

  irq_steer u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .irq_req_i    (req),
    .mode_we_i    (we),
    .mode_wdata_i (wdata),
    .card_dir_ni  (dir_n),
    .host_irq_no  (host_n),
    .card_irq_no  (card_n)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // expected {card_n, host_n} from requirements, dir assumed settled
  function automatic logic [3:0] model(input logic [1:0] r, input logic dl);
    logic [1:0] h = '1, cd = '1;
    for (int i = 0; i < 2; i++) begin
      if (r[i]) begin
        case (m[i])
          2'b00: if (dl) cd[i] = 1'b0; else h[i] = 1'b0;
          2'b01: h[i] = 1'b0;
          2'b10: cd[i] = 1'b0;
          default: ;
        endcase
      end
    end
    return {cd, h};
  endfunction

  task automatic chk(input string tag, input logic [3:0] exp);
    checks++;
    if ({card_n, host_n} !== exp) begin
      errors++;
      $display("FAIL %s: {card,host} actual=%b expected=%b", tag, {card_n, host_n}, exp);
    end
  endtask

  task automatic wr_mode(input int core, input logic [1:0] v);
    we = '0;
    we[core] = 1'b1;
    wdata = '0;
    wdata[2*core +: 2] = v;
    m[core] = v;
    step(1);
    we = '0;
    wdata = '0;
    step(1);
  endtask

  task automatic t_reset();
    req = 2'b11;
    step(2);
    chk("R1 outputs held in reset", 4'b1111);
    rst_n = 1'b1;
    req = 2'b00;
    step(2);
    chk("R1 idle after reset", 4'b1111);
    req = 2'b01;
    step(1);
    chk("R1 mode reset to 0 routes core0 to A", model(2'b01, 1'b0));
    req = 2'b00;
    step(1);
  endtask

  task automatic t_mode0_host();
    req = 2'b10;
    step(1);
    chk("R2 core1 to B", 4'b1101);
    req = 2'b11;
    step(1);
    chk("R2 R4 both cores to own host line", 4'b1100);
    req = 2'b00;
    step(1);
  endtask

  task automatic t_dir_sync();
    req = 2'b11;
    step(1);
    dir_n = 1'b0;
    step(1);
    chk("R9 edge1 unchanged", 4'b1100);
    step(1);
    chk("R9 edge2 unchanged", 4'b1100);
    step(1);
    chk("R9 R3 edge3 to card lines", 4'b0011);
    req = 2'b01;
    step(1);
    chk("R3 R4 core0 on C only", 4'b1011);
    dir_n = 1'b1;
    step(2);
    chk("R9 return edge2 still card", 4'b1011);
    step(1);
    chk("R9 return edge3 host", 4'b1110);
    req = 2'b00;
    step(1);
  endtask

  task automatic t_forced();
    wr_mode(0, 2'b01);
    wr_mode(1, 2'b10);
    req = 2'b11;
    step(1);
    chk("R5 R6 dir high", model(2'b11, 1'b0));
    dir_n = 1'b0;
    step(3);
    chk("R5 R6 dir low", model(2'b11, 1'b1));
    dir_n = 1'b1;
    step(3);
    req = 2'b00;
    wr_mode(0, 2'b00);
    wr_mode(1, 2'b00);
  endtask

  task automatic t_mask_indep();
    req = 2'b11;
    we = 2'b01;
    wdata = 4'b1111;
    m[0] = 2'b11;
    step(1);
    we = '0;
    wdata = '0;
    chk("R11 edge1 old mode", 4'b1100);
    step(1);
    chk("R11 R7 R8 core0 masked core1 kept", 4'b1101);
    dir_n = 1'b0;
    step(3);
    chk("R7 masked with dir low", 4'b0111);
    dir_n = 1'b1;
    step(3);
    req = 2'b00;
    wr_mode(0, 2'b00);
  endtask

  task automatic t_stacked();
    req = 2'b01;
    step(1);
    chk("R10 asserted", 4'b1110);
    req = 2'b00;
    step(1);
    chk("R10 released one edge after drop", 4'b1111);
    req = 2'b01;
    step(1);
    chk("R10 reasserts for stacked interrupt", 4'b1110);
    step(3);
    chk("R10 held while level high", 4'b1110);
    req = 2'b00;
    step(1);
  endtask

  task automatic t_sweep();
    dir_n = 1'b0;
    step(3);
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        wr_mode(0, 2'(a));
        wr_mode(1, 2'(b));
        req = 2'b11;
        step(1);
        chk("R4 R5 R6 R7 sweep dir low", model(2'b11, 1'b1));
        req = 2'b00;
        step(1);
      end
    end
    dir_n = 1'b1;
    step(3);
  endtask

  initial begin
    m[0] = 2'b00;
    m[1] = 2'b00;
    t_reset();
    t_mode0_host();
    t_dir_sync();
    t_forced();
    t_mask_indep();
    t_stacked();
    t_sweep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule